// File: doc/BRIEF.md
# Saturating ALU with sticky flags

A 32-bit integer arithmetic core that computes its result in the same cycle the operands and operation code arrive. It offers wrapping add, wrapping subtract, signed multiply that keeps the low word, saturating add and saturating subtract. It also offers four bitwise and move operations. Each arithmetic result comes with an overflow flag and an advance-overflow flag. The advance-overflow flag is set when the two most significant result bits differ, which warns that the value is close to leaving the representable range.

Two sticky bits sit beside the live flags, and they only ever accumulate. One remembers any overflow and the other remembers any advance-overflow. They take in the live flags on the next clock edge, but only when the flag-update enable is high during an arithmetic operation. They stay set until a synchronous reset or the sticky-clear input removes them. The non-arithmetic operations neither read nor disturb any status. While one of them is selected, the live flag outputs show the flags of the last arithmetic operation that was committed.

Top module: `sat_alu`

## Requirements
- R1: Operation code 0 gives a_i+b_i and code 1 gives a_i-b_i, both modulo 2^32. The overflow flag is high when the true signed result lies outside [-2^31, 2^31-1].
- R2: Code 2 gives the low 32 bits of the signed 64-bit product a_i*b_i. The overflow flag is high when the full product does not fit in 32 signed bits.
- R3: Code 3 adds and code 4 subtracts, both saturating. A true result above 2^31-1 yields 0x7FFFFFFF and a true result below -2^31 yields 0x80000000, each with the overflow flag high. Any other true result is passed through with the overflow flag low.
- R4: During an arithmetic operation, the advance-overflow flag is bit 31 XOR bit 30 of the result. For codes 3 and 4 these two bits come from the unclamped true result.
- R5: If flag_we_i is high during codes 0 to 4, the sticky overflow bit becomes its old value OR the overflow flag on the next edge. No operation ever clears it.
- R6: Under the same condition as R5, the sticky advance-overflow bit becomes its old value OR the advance-overflow flag on the next edge.
- R7: Code 5 gives a AND b, code 6 gives a OR b, code 7 gives a XOR b and code 8 gives b. These codes leave both sticky bits unchanged even when flag_we_i is high. While they are selected, v_o and av_o show the flags of the most recent committed arithmetic operation.
- R8: With flag_we_i low, no operation changes the sticky bits or the held flags. v_o and av_o still show the current arithmetic flags.
- R9: rst or sticky_clr_i clears the sticky bits and the held flags on the next edge. This takes priority over a same-cycle update.
- R10: Codes 9 to 15 give a zero result and behave like the codes of R7 for status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand (signed) |
| b_i | input | 32 | Second operand (signed) |
| flag_we_i | input | 1 | Commit the flags into sticky and held state |
| sticky_clr_i | input | 1 | Clear the sticky bits and held flags |
| result_o | output | 32 | Operation result |
| v_o | output | 1 | Overflow flag |
| av_o | output | 1 | Advance-overflow flag |
| sv_o | output | 1 | Sticky overflow |
| sav_o | output | 1 | Sticky advance-overflow |

## Verification
Within one cycle, a sticky clear can meet an enabled arithmetic operation that overflows. The two would pull the sticky bits in opposite directions. The bench provokes this by raising sticky_clr_i together with flag_we_i during a saturating add that overflows. On the following cycle it expects both sticky bits and the held flags to be zero. A second pairing is also exercised: a live overflow flag that is high while flag_we_i is low. Here the bench judges the ports by the live flag being high while the sticky bits stay where they were.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_ADDS = 4'd3,
    OP_SUBS = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_MOV  = 4'd8
  } alu_op_e;

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op <= 4'd4);
  endfunction

  function automatic logic op_is_sat(input logic [3:0] op);
    return (op == 4'd3) || (op == 4'd4);
  endfunction

endpackage

// File: rtl/sat_alu_wrap.sv
module sat_alu_wrap #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         ovf,
  output logic         adv
);
  localparam int PW = 2 * W;

  function automatic logic add_ovf(input logic [W-1:0] x, y, r);
    logic [W-1:0] t;
    t = (r ^ x) & ~(x ^ y);
    return t[W-1];
  endfunction

  function automatic logic sub_ovf(input logic [W-1:0] x, y, r);
    logic [W-1:0] t;
    t = (r ^ x) & (x ^ y);
    return t[W-1];
  endfunction

  logic [W-1:0]  sum_w, dif_w;
  logic [PW-1:0] prod_w;
  logic [W-1:0]  prod_hi, prod_lo;

  assign sum_w   = a + b;
  assign dif_w   = a - b;
  assign prod_w  = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
  assign prod_lo = prod_w[W-1:0];
  assign prod_hi = prod_w[PW-1:W];

  always_comb begin
    res = '0;
    ovf = 1'b0;
    case (op)
      4'd0: begin res = sum_w;   ovf = add_ovf(a, b, sum_w); end
      4'd1: begin res = dif_w;   ovf = sub_ovf(a, b, dif_w); end
      4'd2: begin res = prod_lo; ovf = (prod_hi != {W{prod_lo[W-1]}}); end
      default: begin res = '0; ovf = 1'b0; end
    endcase
    adv = res[W-1] ^ res[W-2];
  end
endmodule

// File: rtl/sat_alu_sat.sv
module sat_alu_sat #(
  parameter int W = 32
) (
  input  logic         do_sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         ovf,
  output logic         adv
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ax, bx, exact;

  assign ax    = {a[W-1], a};
  assign bx    = {b[W-1], b};
  assign exact = do_sub ? (ax - bx) : (ax + bx);

  always_comb begin
    ovf = exact[W] ^ exact[W-1];
    if (!ovf)          res = exact[W-1:0];
    else if (exact[W]) res = NEG_LIM;
    else               res = POS_LIM;
    adv = exact[W-1] ^ exact[W-2];
  end
endmodule

// File: rtl/sat_alu_logic.sv
module sat_alu_logic #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      4'd5:    res = a & b;
      4'd6:    res = a | b;
      4'd7:    res = a ^ b;
      4'd8:    res = b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/sat_alu_sticky.sv
module sat_alu_sticky (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic commit,
  input  logic v_in,
  input  logic av_in,
  output logic sv,
  output logic sav,
  output logic v_hold,
  output logic av_hold
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sv      <= 1'b0;
      sav     <= 1'b0;
      v_hold  <= 1'b0;
      av_hold <= 1'b0;
    end else if (commit) begin
      sv      <= sv | v_in;
      sav     <= sav | av_in;
      v_hold  <= v_in;
      av_hold <= av_in;
    end
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         flag_we_i,
  input  logic         sticky_clr_i,
  output logic [W-1:0] result_o,
  output logic         v_o,
  output logic         av_o,
  output logic         sv_o,
  output logic         sav_o
);
  logic         arith_sel, sat_sel, commit_ev;
  logic [W-1:0] wrap_res, sat_res, log_res;
  logic         wrap_v, wrap_av, sat_v, sat_av;
  logic         raw_v, raw_av, v_hold, av_hold;

  assign arith_sel = op_is_arith(op_i);
  assign sat_sel   = op_is_sat(op_i);
  assign commit_ev = flag_we_i && arith_sel;

  sat_alu_wrap #(.W(W)) u_wrap (
    .op(op_i), .a(a_i), .b(b_i), .res(wrap_res), .ovf(wrap_v), .adv(wrap_av)
  );

  sat_alu_sat #(.W(W)) u_sat (
    .do_sub(op_i == OP_SUBS), .a(a_i), .b(b_i),
    .res(sat_res), .ovf(sat_v), .adv(sat_av)
  );

  sat_alu_logic #(.W(W)) u_logic (
    .op(op_i), .a(a_i), .b(b_i), .res(log_res)
  );

  assign raw_v  = sat_sel ? sat_v  : wrap_v;
  assign raw_av = sat_sel ? sat_av : wrap_av;

  sat_alu_sticky u_sticky (
    .clk(clk), .rst(rst), .clr(sticky_clr_i), .commit(commit_ev),
    .v_in(raw_v), .av_in(raw_av),
    .sv(sv_o), .sav(sav_o), .v_hold(v_hold), .av_hold(av_hold)
  );

  always_comb begin
    if (sat_sel)        result_o = sat_res;
    else if (arith_sel) result_o = wrap_res;
    else                result_o = log_res;
    v_o  = arith_sel ? raw_v  : v_hold;
    av_o = arith_sel ? raw_av : av_hold;
  end
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         flag_we_i,
  input logic         sticky_clr_i,
  input logic [W-1:0] result_o,
  input logic         v_o,
  input logic         av_o,
  input logic         sv_o,
  input logic         sav_o,
  input logic         arith_sel,
  input logic         sat_sel
);
  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  AST_SV_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (sv_o && !sticky_clr_i) |=> sv_o); // R5
  AST_SV_CATCHES_V: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && arith_sel && v_o && !sticky_clr_i) |=> sv_o); // R5
  AST_SAV_CATCHES_AV: assert property (@(posedge clk) disable iff (rst)
    (flag_we_i && arith_sel && av_o && !sticky_clr_i) |=> sav_o); // R6
  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (sat_sel && v_o) |-> (result_o == POS_LIM || result_o == NEG_LIM)); // R3
  AST_NONARITH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!arith_sel && !sticky_clr_i) |=> ($stable(sv_o) && $stable(sav_o))); // R7
  AST_NO_WE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!flag_we_i && !sticky_clr_i) |=> ($stable(sv_o) && $stable(sav_o))); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    sticky_clr_i |=> (!sv_o && !sav_o)); // R9
endmodule

bind sat_alu sat_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .flag_we_i(flag_we_i), .sticky_clr_i(sticky_clr_i),
  .result_o(result_o), .v_o(v_o), .av_o(av_o), .sv_o(sv_o), .sav_o(sav_o),
  .arith_sel(arith_sel), .sat_sel(sat_sel)
);

// File: tb/sat_alu_test.sv
module sat_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = 4'd5;
  logic [31:0] a_i = '0, b_i = '0;
  logic        flag_we_i = 1'b0, sticky_clr_i = 1'b0;
  logic [31:0] result_o;
  logic        v_o, av_o, sv_o, sav_o;

  sat_alu uut (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flag_we_i(flag_we_i), .sticky_clr_i(sticky_clr_i),
    .result_o(result_o), .v_o(v_o), .av_o(av_o), .sv_o(sv_o), .sav_o(sav_o)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [31:0] res;
    logic        v, av, sv, sav;
    string       tag;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int checks = 0, errors = 0;
  bit done = 0;
  logic m_sv = 0, m_sav = 0, m_hv = 0, m_hav = 0;

  task automatic drive(input logic [3:0] op, input logic [31:0] a, b,
                       input logic we, clr, input string tag);
    exp_t e;
    longint la, lb, ex;
    logic [63:0] exb;
    logic arith;
    la = longint'($signed(a));
    lb = longint'($signed(b));
    arith = (op <= 4'd4);
    e.tag = tag;
    e.v = 0; e.av = 0; e.res = '0;
    case (op)
      4'd0, 4'd1, 4'd3, 4'd4: begin
        ex = (op == 4'd0 || op == 4'd3) ? la + lb : la - lb;
        exb = ex;
        e.v = (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
        if (op == 4'd3 || op == 4'd4) begin
          e.res = !e.v ? exb[31:0] : (ex > 0 ? 32'h7FFFFFFF : 32'h80000000);
          e.av = exb[31] ^ exb[30];
        end else begin
          e.res = exb[31:0];
          e.av = e.res[31] ^ e.res[30];
        end
      end
      4'd2: begin
        ex = la * lb; exb = ex;
        e.res = exb[31:0];
        e.v = (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
        e.av = e.res[31] ^ e.res[30];
      end
      4'd5: e.res = a & b;
      4'd6: e.res = a | b;
      4'd7: e.res = a ^ b;
      4'd8: e.res = b;
      default: e.res = '0;
    endcase
    if (!arith) begin e.v = m_hv; e.av = m_hav; end
    e.sv = m_sv; e.sav = m_sav;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; flag_we_i = we; sticky_clr_i = clr;
    #1;
    q.push_back(e);
    ->chk_ev;
    if (clr) begin m_sv = 0; m_sav = 0; m_hv = 0; m_hav = 0; end
    else if (we && arith) begin
      m_sv = m_sv | e.v; m_sav = m_sav | e.av; m_hv = e.v; m_hav = e.av;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (result_o !== e.res || v_o !== e.v || av_o !== e.av ||
            sv_o !== e.sv || sav_o !== e.sav) begin
          errors++;
          $display("FAIL %s: got res=%h v=%b av=%b sv=%b sav=%b exp res=%h v=%b av=%b sv=%b sav=%b",
                   e.tag, result_o, v_o, av_o, sv_o, sav_o,
                   e.res, e.v, e.av, e.sv, e.sav);
        end
      end
    end
  end

  initial begin : watchdog
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    drive(4'd5, 32'hFFFF0000, 32'h0F0F0F0F, 0, 0, "R9 reset state");
    drive(4'd0, 32'd1, 32'd2, 1, 0, "R1 add small");
    drive(4'd0, 32'h7FFFFFFF, 32'd1, 1, 0, "R1 add overflow");
    drive(4'd8, 32'h0, 32'h12345678, 1, 0, "R5 sv set after overflow");
    drive(4'd1, 32'h80000000, 32'd1, 1, 0, "R1 sub wrap");
    drive(4'd1, 32'd5, 32'd9, 1, 0, "R1 sub negative");
    drive(4'd2, 32'h00010000, 32'h00010000, 1, 1, "R2 mul overflow with clear R9");
    drive(4'd2, 32'hFFFFFFFD, 32'd5, 1, 0, "R2 mul -3*5");
    drive(4'd2, 32'h00010000, 32'h00010000, 1, 0, "R2 mul overflow");
    drive(4'd3, 32'h7FFFFFFF, 32'h7FFFFFFF, 1, 1, "R3 adds clamp high, R4 av from exact");
    drive(4'd4, 32'h80000000, 32'd1, 1, 0, "R3 subs clamp low, R4 av from exact");
    drive(4'd3, 32'h40000000, 32'd0, 1, 0, "R4 adds av without v");
    drive(4'd5, 32'hF0F0F0F0, 32'hFF00FF00, 1, 0, "R7 and holds flags R6");
    drive(4'd6, 32'hF0F0F0F0, 32'h0000FFFF, 1, 0, "R7 or");
    drive(4'd7, 32'hAAAA5555, 32'hFFFF0000, 1, 0, "R7 xor");
    drive(4'd12, 32'hFFFFFFFF, 32'hFFFFFFFF, 1, 0, "R10 unused code");
    drive(4'd0, 32'd3, 32'd4, 1, 1, "R9 clear");
    drive(4'd3, 32'h7FFFFFFF, 32'd10, 0, 0, "R8 overflow without enable");
    drive(4'd8, 32'h0, 32'h1, 1, 0, "R8 sticky untouched");
    drive(4'd4, 32'h7FFFFFFF, 32'hFFFFFFFF, 1, 1, "R9 clear beats update");
    drive(4'd15, 32'h1, 32'h2, 1, 0, "R9 clear result R10");
    for (int i = 0; i < 300; i++) begin
      logic [3:0] rop;
      rop = 4'($urandom_range(0, 15));
      drive(rop, $urandom, ($urandom_range(0, 3) == 0) ? 32'h7FFFFFFF : $urandom,
            1'($urandom_range(0, 1)), ($urandom_range(0, 19) == 0),
            "R5 R6 random mix");
    end
    drive(4'd5, 32'h0, 32'h0, 0, 0, "R5 final state");
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule